// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block is a direct-mapped cache that sits between one CPU and a shared memory bus. Reads that find their word in the cache are answered locally without touching the bus. Reads that miss fetch the word from memory, install it in the cache and return it to the CPU. Every CPU write goes to memory, so memory always holds the current value. A write also updates the cache, but only when the word is already cached: a write that misses never allocates a line.

Other masters on the bus are watched through a snoop port. When another master writes a word that this cache holds, the line holding it is invalidated, so the CPU's next read of that word fetches the fresh value from memory. Snooped reads from other masters are ignored.

The CPU holds a request with its address and data until the controller answers with a one-cycle ready pulse. The bus side raises a request and keeps it up until it sees grant and acknowledge together. Arbitration among caches is outside the block.

Top module: `wt_snoop_cache`

## Requirements
- R1: A CPU read whose word is not cached issues exactly one bus read of that word address, installs the returned word, and returns it to the CPU.
- R2: A CPU read whose word is cached returns the cached word with no bus transaction, with ready seen two clock edges after the request is first presented.
- R3: A CPU write to an uncached word writes memory through one bus write and leaves every line unchanged, so an earlier cached word at the same index still hits.
- R4: A CPU write to a cached word writes memory through one bus write and also updates the line, so a later read hits and returns the new word.
- R5: A snooped write (snoop valid with snoop write high) to a cached word address invalidates that line, so the next CPU read of it misses and returns the word held in memory.
- R6: A snooped read (snoop valid with snoop write low) has no effect: a cached word still hits afterwards.
- R7: A CPU write keeps ready low until its bus write completes; ready pulses on the edge after the bus transaction completes, so write latency grows one cycle per cycle of memory delay (four edges with zero delay).
- R8: When a snooped write names the same word address in the cycle a read fill completes, the CPU still receives the fill data, but the line is left invalid.
- R9: Reset clears every valid bit, so no word hits after reset.
- R10: A snooped write to a word at the same index but with a different tag leaves the cached line valid.
- R11: A bus request stays high with stable address, direction and write data until grant and acknowledge are both high, and drops on the next edge; ready is a single-cycle pulse.
- R12: Address layout: word addresses are AW bits; the low log2(LINES) bits select the line and the remaining upper bits are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Read data, valid with ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Bus write data |
| bus_gnt | input | 1 | Bus grant |
| bus_ack | input | 1 | Transaction done; read data valid |
| bus_rdata | input | DW | Bus read data |
| snp_valid | input | 1 | Another master's bus cycle is visible |
| snp_we | input | 1 | That cycle is a write |
| snp_addr | input | AW | Word address of that cycle |

## Verification
The bench first establishes that a word is cached, then checks whether a bus read follows each disturbance: a remote write, a remote read, and a remote write to the same index under another tag. A design that ignored snoops would return stale data. One that matched on index alone would throw away good lines. The hardest case puts a remote write in the exact cycle a fill completes; a design that let the fill win would keep a stale line valid, and the follow-up read would hit instead of missing. Write latency is measured at two memory delays, and a grant withheld mid-request must stall the CPU. A design that acknowledged writes early, or that treated an uncached write as an allocation, shows up in the cycle counts and in the bus read counts.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_BUS  = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 16,
  parameter int TW    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(LINES)-1:0] look_idx,
  input  logic [TW-1:0]            look_tag,
  output logic                     look_hit,
  input  logic                     fill_en,
  input  logic [$clog2(LINES)-1:0] fill_idx,
  input  logic [TW-1:0]            fill_tag,
  input  logic                     snp_en,
  input  logic [$clog2(LINES)-1:0] snp_idx,
  input  logic [TW-1:0]            snp_tag,
  output logic [LINES-1:0]         vld_vec,
  output logic [LINES*TW-1:0]      tag_flat
);
  localparam int IW = $clog2(LINES);

  logic [TW-1:0]    tags [LINES];
  logic [LINES-1:0] vld;

  // a fill is cancelled when a remote write names the very word being filled
  logic fill_cancel;
  assign fill_cancel = snp_en && (snp_idx == fill_idx) && (snp_tag == fill_tag);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic kill;
    assign kill = snp_en && vld[g] && (snp_idx == IW'(g)) && (tags[g] == snp_tag);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[g] <= 1'b0;
      end else if (fill_en && (fill_idx == IW'(g))) begin
        vld[g] <= !fill_cancel;
      end else if (kill) begin
        vld[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && (fill_idx == IW'(g))) begin
        tags[g] <= fill_tag;
      end
    end

    assign tag_flat[g*TW +: TW] = tags[g];
  end

  assign look_hit = vld[look_idx] && (tags[look_idx] == look_tag);
  assign vld_vec  = vld;
endmodule

// File: rtl/wtc_data_ram.sv
module wtc_data_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_q,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
    if (rd_en) begin
      rd_q <= mem[rd_idx];
    end
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic [IW-1:0]    look_idx,
  output logic [AW-IW-1:0] look_tag,
  input  logic             look_hit,
  output logic             ram_rd_en,
  output logic [IW-1:0]    ram_rd_idx,
  input  logic [DW-1:0]    ram_q,
  output logic             ram_we,
  output logic [DW-1:0]    ram_wd,
  output logic             fill_en
);
  wtc_state_e    state;
  logic [AW-1:0] lat_addr;
  logic          lat_we;
  logic [DW-1:0] lat_wd;
  logic          bus_done;

  assign bus_done   = (state == ST_BUS) && bus_gnt && bus_ack;
  assign look_idx   = lat_addr[IW-1:0];
  assign look_tag   = lat_addr[AW-1:IW];
  assign ram_rd_en  = (state == ST_IDLE) && cpu_req;
  assign ram_rd_idx = cpu_addr[IW-1:0];
  assign fill_en    = bus_done && !lat_we;
  assign ram_we     = fill_en || ((state == ST_LOOK) && lat_we && look_hit);
  assign ram_wd     = lat_we ? lat_wd : bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lat_addr  <= '0;
      lat_we    <= 1'b0;
      lat_wd    <= '0;
      cpu_rdata <= '0;
      cpu_ready <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req && !cpu_ready) begin
            lat_addr <= cpu_addr;
            lat_we   <= cpu_we;
            lat_wd   <= cpu_wdata;
            state    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!lat_we && look_hit) begin
            cpu_rdata <= ram_q;
            cpu_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            bus_req   <= 1'b1;
            bus_we    <= lat_we;
            bus_addr  <= lat_addr;
            bus_wdata <= lat_wd;
            state     <= ST_BUS;
          end
        end
        ST_BUS: begin
          if (bus_done) begin
            bus_req   <= 1'b0;
            cpu_ready <= 1'b1;
            if (!lat_we) begin
              cpu_rdata <= bus_rdata;
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LINES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic          snp_we,
  input  logic [AW-1:0] snp_addr
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  logic [IW-1:0]       look_idx;
  logic [TW-1:0]       look_tag;
  logic                look_hit;
  logic                ram_rd_en;
  logic [IW-1:0]       ram_rd_idx;
  logic [DW-1:0]       ram_q;
  logic                ram_we;
  logic [DW-1:0]       ram_wd;
  logic                fill_en;
  logic [LINES-1:0]    vld_vec;
  logic [LINES*TW-1:0] tag_flat;

  wtc_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .look_idx(look_idx), .look_tag(look_tag), .look_hit(look_hit),
    .ram_rd_en(ram_rd_en), .ram_rd_idx(ram_rd_idx), .ram_q(ram_q),
    .ram_we(ram_we), .ram_wd(ram_wd), .fill_en(fill_en)
  );

  wtc_tag_store #(.LINES(LINES), .TW(TW)) u_tags (
    .clk(clk), .rst(rst),
    .look_idx(look_idx), .look_tag(look_tag), .look_hit(look_hit),
    .fill_en(fill_en), .fill_idx(look_idx), .fill_tag(look_tag),
    .snp_en(snp_valid && snp_we),
    .snp_idx(snp_addr[IW-1:0]), .snp_tag(snp_addr[AW-1:IW]),
    .vld_vec(vld_vec), .tag_flat(tag_flat)
  );

  wtc_data_ram #(.DEPTH(LINES), .DW(DW)) u_ram (
    .clk(clk),
    .rd_en(ram_rd_en), .rd_idx(ram_rd_idx), .rd_q(ram_q),
    .wr_en(ram_we), .wr_idx(look_idx), .wr_data(ram_wd)
  );
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LINES = 16
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               cpu_we,
  input logic                               cpu_ready,
  input logic                               bus_req,
  input logic                               bus_we,
  input logic [AW-1:0]                      bus_addr,
  input logic [DW-1:0]                      bus_wdata,
  input logic                               bus_gnt,
  input logic                               bus_ack,
  input logic                               snp_valid,
  input logic                               snp_we,
  input logic [AW-1:0]                      snp_addr,
  input logic [LINES-1:0]                   vld_vec,
  input logic [LINES*(AW-$clog2(LINES))-1:0] tag_flat
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  function automatic logic holds(input logic [AW-1:0] a);
    return vld_vec[a[IW-1:0]] && (tag_flat[a[IW-1:0]*TW +: TW] == a[AW-1:IW]);
  endfunction

  // R9: every valid bit is clear after a reset edge
  a_r9_reset_clears: assert property (@(posedge clk) rst |=> (vld_vec == '0));

  // R5 / R8: a remote write leaves its word uncached on the following edge
  a_r5_snoop_invalidates: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_we) |=> !holds($past(snp_addr)));

  // R7: a write is only reported done after its bus transaction completed
  a_r7_write_after_bus: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && cpu_we) |-> $past(bus_ack && bus_gnt));

  // R11: ready is a single-cycle pulse
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R11: an open bus request holds its fields
  a_r11_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !(bus_gnt && bus_ack)) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R11: a completed request drops on the next edge
  a_r11_bus_release: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_ack) |=> !bus_req);
endmodule

bind wt_snoop_cache wtc_chk #(.AW(AW), .DW(DW), .LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_gnt(bus_gnt), .bus_ack(bus_ack),
  .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr),
  .vld_vec(vld_vec), .tag_flat(tag_flat)
);

// File: tb/sim_wt_snoop_cache.sv
`timescale 1ns/1ps
module sim_wt_snoop_cache;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_ready;
  logic bus_req, bus_we, bus_gnt;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_t_v = 1'b0, snp_t_we = 1'b0;
  logic [AW-1:0] snp_t_a = '0;
  logic snp_f_v = 1'b0;
  logic [AW-1:0] snp_f_a = '0;
  logic snp_valid, snp_we;
  logic [AW-1:0] snp_addr;

  logic gnt_en = 1'b1;
  int   lat = 0;
  int   lat_cnt = 0;
  bit   race_on_fill = 1'b0;
  logic [DW-1:0] mem [1024];
  int rd_cnt = 0, wr_cnt = 0;
  int total = 0, bad = 0, cyc_all = 0;

  always #4 clk = ~clk;

  assign bus_gnt   = bus_req && gnt_en;
  assign snp_valid = snp_t_v | snp_f_v;
  assign snp_we    = snp_f_v ? 1'b1 : snp_t_we;
  assign snp_addr  = snp_f_v ? snp_f_a : snp_t_a;

  wt_snoop_cache #(.AW(AW), .DW(DW), .LINES(16)) u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr)
  );

  // behavioural memory: acks after lat granted cycles
  always @(posedge clk) begin
    bus_ack <= 1'b0;
    snp_f_v <= 1'b0;
    if (bus_req && bus_gnt && !bus_ack) begin
      if (lat_cnt == lat) begin
        bus_ack <= 1'b1;
        lat_cnt <= 0;
        if (bus_we) mem[bus_addr] <= bus_wdata;
        else bus_rdata <= mem[bus_addr];
        if (race_on_fill && !bus_we) begin
          snp_f_v <= 1'b1;
          snp_f_a <= bus_addr;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (bus_req && bus_gnt && bus_ack) begin
      if (bus_we) wr_cnt <= wr_cnt + 1;
      else rd_cnt <= rd_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc_all <= cyc_all + 1;
    if (cyc_all > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog (all R) act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 500);
    q = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic remote(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    if (we) mem[a] = d;
    snp_t_v = 1'b1; snp_t_we = we; snp_t_a = a;
    @(negedge clk);
    snp_t_v = 1'b0; snp_t_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] init_val(input int i);
    return 32'hA500_0000 ^ (i * 32'h0001_0203);
  endfunction

  task automatic t_reset_state();
    chk("R9 ready idle after reset", {31'b0, cpu_ready}, 32'd0);
    chk("R11 bus idle after reset", {31'b0, bus_req}, 32'd0);
  endtask

  task automatic t_r1_r2_read();
    logic [31:0] q; int c; int r0;
    r0 = rd_cnt;
    access(1'b0, 10'h013, '0, q, c);
    chk("R1 miss data", q, init_val('h013));
    chk("R1 one bus read", rd_cnt - r0, 1);
    r0 = rd_cnt;
    access(1'b0, 10'h013, '0, q, c);
    chk("R2 hit data", q, init_val('h013));
    chk("R2 hit no bus", rd_cnt - r0, 0);
    chk("R2 hit latency", c, 2);
  endtask

  task automatic t_r4_write_hit();
    logic [31:0] q; int c; int r0, w0;
    w0 = wr_cnt; r0 = rd_cnt;
    access(1'b1, 10'h013, 32'hDEAD_0013, q, c);
    chk("R4 one bus write", wr_cnt - w0, 1);
    chk("R4 memory updated", mem[10'h013], 32'hDEAD_0013);
    access(1'b0, 10'h013, '0, q, c);
    chk("R4 read new value", q, 32'hDEAD_0013);
    chk("R4 read hits", rd_cnt - r0, 0);
  endtask

  task automatic t_r3_write_miss();
    logic [31:0] q; int c; int r0, w0;
    access(1'b0, 10'h022, '0, q, c);      // index 2, tag 2 cached
    w0 = wr_cnt; r0 = rd_cnt;
    access(1'b1, 10'h222, 32'hBEEF_0222, q, c); // index 2, tag 34: miss
    chk("R3 one bus write", wr_cnt - w0, 1);
    chk("R3 memory updated", mem[10'h222], 32'hBEEF_0222);
    access(1'b0, 10'h022, '0, q, c);
    chk("R3 old line still hits", rd_cnt - r0, 0);
    chk("R3 old line data", q, init_val('h022));
    access(1'b0, 10'h222, '0, q, c);
    chk("R3 written word not allocated", rd_cnt - r0, 1);
    chk("R3 written word from memory", q, 32'hBEEF_0222);
  endtask

  task automatic t_r7_write_latency();
    logic [31:0] q; int c0, c3;
    lat = 0;
    access(1'b1, 10'h300, 32'h1111_0300, q, c0);
    lat = 3;
    access(1'b1, 10'h301, 32'h2222_0301, q, c3);
    lat = 0;
    chk("R7 write latency zero delay", c0, 4);
    chk("R7 write latency tracks memory", c3, 7);
  endtask

  task automatic t_r5_snoop_write();
    logic [31:0] q; int c; int r0;
    access(1'b0, 10'h030, '0, q, c);
    remote(1'b1, 10'h030, 32'hCAFE_0030);
    r0 = rd_cnt;
    access(1'b0, 10'h030, '0, q, c);
    chk("R5 invalidated line misses", rd_cnt - r0, 1);
    chk("R5 fresh data", q, 32'hCAFE_0030);
  endtask

  task automatic t_r6_snoop_read();
    logic [31:0] q; int c; int r0;
    access(1'b0, 10'h031, '0, q, c);
    remote(1'b0, 10'h031, '0);
    r0 = rd_cnt;
    access(1'b0, 10'h031, '0, q, c);
    chk("R6 snooped read no effect", rd_cnt - r0, 0);
    chk("R6 data", q, init_val('h031));
  endtask

  task automatic t_r10_other_tag();
    logic [31:0] q; int c; int r0;
    access(1'b0, 10'h041, '0, q, c);
    remote(1'b1, 10'h141, 32'h7777_0141);
    r0 = rd_cnt;
    access(1'b0, 10'h041, '0, q, c);
    chk("R10 other tag keeps line", rd_cnt - r0, 0);
    chk("R10 data", q, init_val('h041));
  endtask

  task automatic t_r8_race();
    logic [31:0] q; int c; int r0;
    race_on_fill = 1'b1;
    access(1'b0, 10'h055, '0, q, c);
    race_on_fill = 1'b0;
    chk("R8 fill data returned", q, init_val('h055));
    r0 = rd_cnt;
    access(1'b0, 10'h055, '0, q, c);
    chk("R8 line left invalid", rd_cnt - r0, 1);
  endtask

  task automatic t_r11_grant();
    logic [31:0] q; int c; int r0;
    bit early;
    r0 = rd_cnt; early = 1'b0;
    gnt_en = 1'b0;
    fork
      access(1'b0, 10'h066, '0, q, c);
      begin
        repeat (10) begin
          @(negedge clk);
          if (cpu_ready) early = 1'b1;
        end
        chk("R11 request held without grant", {31'b0, bus_req}, 32'd1);
        chk("R11 no completion without grant", {31'b0, early}, 32'd0);
        gnt_en = 1'b1;
      end
    join
    chk("R11 data after grant", q, init_val('h066));
    chk("R11 one bus read", rd_cnt - r0, 1);
  endtask

  task automatic t_r9_reset_clears();
    logic [31:0] q; int c; int r0;
    access(1'b0, 10'h07A, '0, q, c);
    do_reset();
    r0 = rd_cnt;
    access(1'b0, 10'h07A, '0, q, c);
    chk("R9 no hit after reset", rd_cnt - r0, 1);
    chk("R12 data at address", q, init_val('h07A));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_r1_r2_read();
    t_r4_write_hit();
    t_r3_write_miss();
    t_r7_write_latency();
    t_r5_snoop_write();
    t_r6_snoop_read();
    t_r10_other_tag();
    t_r8_race();
    t_r11_grant();
    t_r9_reset_clears();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule